// File: doc/BRIEF.md
# Word-Parallel Scan Datapath

A four-register, 16-bit datapath whose registers can be strung into one word-wide shift path for test. When `scan_en` is high, each register copies the one before it on every clock, so a word driven on `scan_in` walks through the registers one stage per cycle and leaves at `scan_out`. The path behaves as sixteen independent single-bit chains, one per bit position, all moving together.

The shift path is built mostly from wiring the datapath already has. The second stage is reached through the existing operand multiplexer in front of it, with one gate forcing its select onto the leg that carries the previous register and one gate forcing its load. The third stage already takes the second register directly, so only its load is forced with an OR. The fourth stage has no plain path from the third, so a dedicated test multiplexer sits in front of it; the first stage likewise takes `scan_in` through a test multiplexer. With `scan_en` low, the control inputs reach the registers unchanged and the datapath does its normal work. Which multiplexer leg carries the chain is a parameter, and the gate that forces the select follows it.

A typical test reads the state by raising `scan_en` for four cycles: `scan_out` shows the last register first, then the third, second and first.

Top module: `scan_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared, so `dout` and `scan_out` read 0.
- R2: With `scan_en` high, the first register loads `scan_in` on every clock, and a word applied on `scan_in` appears on `scan_out` after exactly four rising edges.
- R3: With `scan_en` high, the second register loads the first register's value on every clock, whatever `load_req[1]` and `sel_r2` are.
- R4: With `scan_en` high, the third register loads the second register's value on every clock, whatever `load_req[2]` is.
- R5: With `scan_en` high, the fourth register loads the third register's value on every clock, whatever `load_req[3]` is and whatever the adder result is.
- R6: With `scan_en` low and `load_req[0]` high, the first register loads `din_a`.
- R7: With `scan_en` low and `load_req[1]` high, the second register loads the first register when `sel_r2` is 1 and `din_b` when `sel_r2` is 0 (default leg setting).
- R8: With `scan_en` low and `load_req[2]` high, the third register loads the second register.
- R9: With `scan_en` low and `load_req[3]` high, the fourth register loads the sum of the second and third registers modulo 2^16.
- R10: With `scan_en` low, a register whose `load_req` bit is low keeps its value, whatever the data inputs do.
- R11: `dout` and `scan_out` both show the fourth register at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Shift-mode enable |
| scan_in | input | 16 | Word shifted into the first register |
| din_a | input | 16 | Functional data for the first register |
| din_b | input | 16 | Functional data on the second register's multiplexer |
| load_req | input | 4 | Per-register load enables from the controller, bit 0 = first register |
| sel_r2 | input | 1 | Select of the second register's multiplexer (1 = first register, 0 = `din_b`) |
| dout | output | 16 | Functional result, the fourth register |
| scan_out | output | 16 | Shift-path output, the fourth register |

## Verification
The bench shifts while holding `sel_r2` on the `din_b` leg with a distinct `din_b` value and all load bits low. A design that failed to force the select would pull `din_b` into the chain, and one that failed to force a load would repeat a stale word instead of advancing. Functional loads, including an adder result that wraps past 0xFFFF, are scanned out afterwards so the inner registers are seen in last-to-first order. Holding cycles with loads low and moving data inputs expose a forced load that leaks into functional mode.

// File: rtl/scan_dp_pkg.sv
package scan_dp_pkg;
    localparam int DP_WIDTH = 16;
    localparam int DP_STAGES = 4;

    // Which leg of the second-stage multiplexer carries the chain.
    typedef enum logic {
        LEG_LOW  = 1'b0,
        LEG_HIGH = 1'b1
    } chain_leg_e;
endpackage

// File: rtl/scan_link_mux.sv
// Reuses an existing two-input multiplexer as a shift link.
module scan_link_mux #(
    parameter int WIDTH = 16,
    parameter scan_dp_pkg::chain_leg_e LEG = scan_dp_pkg::LEG_HIGH
) (
    input  logic             scan_en,
    input  logic             func_sel,
    input  logic             func_ld,
    input  logic [WIDTH-1:0] leg0,
    input  logic [WIDTH-1:0] leg1,
    output logic [WIDTH-1:0] d_out,
    output logic             ld_out
);
    logic sel_eff;

    generate
        if (LEG == scan_dp_pkg::LEG_HIGH) begin : g_force_high
            always_comb sel_eff = func_sel | scan_en;
        end else begin : g_force_low
            always_comb sel_eff = func_sel & ~scan_en;
        end
    endgenerate

    always_comb begin
        ld_out = func_ld | scan_en;
        d_out  = sel_eff ? leg1 : leg0;
    end
endmodule

// File: rtl/scan_link_direct.sv
// Existing direct connection: only the load is forced.
module scan_link_direct #(
    parameter int WIDTH = 16
) (
    input  logic             scan_en,
    input  logic             func_ld,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] d_out,
    output logic             ld_out
);
    always_comb begin
        ld_out = func_ld | scan_en;
        d_out  = src;
    end
endmodule

// File: rtl/scan_link_testmux.sv
// No usable path: a dedicated test multiplexer in front of the register.
module scan_link_testmux #(
    parameter int WIDTH = 16
) (
    input  logic             scan_en,
    input  logic             func_ld,
    input  logic [WIDTH-1:0] func_d,
    input  logic [WIDTH-1:0] chain_d,
    output logic [WIDTH-1:0] d_out,
    output logic             ld_out
);
    always_comb begin
        ld_out = func_ld | scan_en;
        d_out  = scan_en ? chain_d : func_d;
    end
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath #(
    parameter int WIDTH = scan_dp_pkg::DP_WIDTH,
    parameter scan_dp_pkg::chain_leg_e R2_LEG = scan_dp_pkg::LEG_HIGH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic [WIDTH-1:0] scan_in,
    input  logic [WIDTH-1:0] din_a,
    input  logic [WIDTH-1:0] din_b,
    input  logic [3:0]       load_req,
    input  logic             sel_r2,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] scan_out
);
    localparam int NSTG = scan_dp_pkg::DP_STAGES;

    typedef struct packed {
        logic [WIDTH-1:0] r1;
        logic [WIDTH-1:0] r2;
        logic [WIDTH-1:0] r3;
        logic [WIDTH-1:0] r4;
    } state_t;

    state_t state_d, state_q;

    logic [WIDTH-1:0] link_d  [NSTG];
    logic [NSTG-1:0]  link_ld;
    logic [WIDTH-1:0] r2_leg0, r2_leg1;
    logic [WIDTH-1:0] sum_r2_r3;

    // Place the previous register on the chosen leg, din_b on the other.
    generate
        if (R2_LEG == scan_dp_pkg::LEG_HIGH) begin : g_leg_hi
            always_comb begin
                r2_leg1 = state_q.r1;
                r2_leg0 = din_b;
            end
        end else begin : g_leg_lo
            always_comb begin
                r2_leg0 = state_q.r1;
                r2_leg1 = din_b;
            end
        end
    endgenerate

    always_comb sum_r2_r3 = state_q.r2 + state_q.r3;

    scan_link_testmux #(.WIDTH(WIDTH)) u_link1 (
        .scan_en (scan_en),
        .func_ld (load_req[0]),
        .func_d  (din_a),
        .chain_d (scan_in),
        .d_out   (link_d[0]),
        .ld_out  (link_ld[0])
    );

    scan_link_mux #(.WIDTH(WIDTH), .LEG(R2_LEG)) u_link2 (
        .scan_en  (scan_en),
        .func_sel (sel_r2),
        .func_ld  (load_req[1]),
        .leg0     (r2_leg0),
        .leg1     (r2_leg1),
        .d_out    (link_d[1]),
        .ld_out   (link_ld[1])
    );

    scan_link_direct #(.WIDTH(WIDTH)) u_link3 (
        .scan_en (scan_en),
        .func_ld (load_req[2]),
        .src     (state_q.r2),
        .d_out   (link_d[2]),
        .ld_out  (link_ld[2])
    );

    scan_link_testmux #(.WIDTH(WIDTH)) u_link4 (
        .scan_en (scan_en),
        .func_ld (load_req[3]),
        .func_d  (sum_r2_r3),
        .chain_d (state_q.r3),
        .d_out   (link_d[3]),
        .ld_out  (link_ld[3])
    );

    always_comb begin
        state_d = state_q;
        if (link_ld[0]) state_d.r1 = link_d[0];
        if (link_ld[1]) state_d.r2 = link_d[1];
        if (link_ld[2]) state_d.r3 = link_d[2];
        if (link_ld[3]) state_d.r4 = link_d[3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dout     = state_q.r4;
    assign scan_out = state_q.r4;

    // Shift-mode links, checked register to register across the edge.
    a_r2_first_takes_scan_in: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> state_q.r1 == $past(scan_in));
    a_r3_mux_link_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> state_q.r2 == $past(state_q.r1));
    a_r4_direct_link_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> state_q.r3 == $past(state_q.r2));
    a_r5_testmux_link_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> state_q.r4 == $past(state_q.r3));
    a_r10_third_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !load_req[2]) |=> $stable(state_q.r3));
    a_r9_sum_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && load_req[3]) |=>
            state_q.r4 == WIDTH'($past(state_q.r2) + $past(state_q.r3)));
endmodule

// File: tb/test_scan_datapath.sv
module test_scan_datapath;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic [W-1:0] scan_in = '0;
    logic [W-1:0] din_a = '0;
    logic [W-1:0] din_b = '0;
    logic [3:0]   load_req = '0;
    logic         sel_r2 = 1'b0;
    logic [W-1:0] dout, scan_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference state of the four stages, built from the requirements.
    logic [W-1:0] m1 = '0, m2 = '0, m3 = '0, m4 = '0;

    always #4 clk = ~clk;

    scan_datapath i_scan_datapath (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .din_a(din_a), .din_b(din_b), .load_req(load_req), .sel_r2(sel_r2),
        .dout(dout), .scan_out(scan_out)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected fourth stage.
    task automatic step(input logic sc, input logic [W-1:0] si, input logic [3:0] ld,
                        input logic sel, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
        logic [W-1:0] n1, n2, n3, n4;
        exp_t e;
        @(negedge clk);
        scan_en = sc; scan_in = si; load_req = ld; sel_r2 = sel; din_a = a; din_b = b;
        n1 = m1; n2 = m2; n3 = m3; n4 = m4;
        if (sc) begin
            n1 = si; n2 = m1; n3 = m2; n4 = m3;
        end else begin
            if (ld[0]) n1 = a;
            if (ld[1]) n2 = sel ? m1 : b;
            if (ld[2]) n3 = m2;
            if (ld[3]) n4 = W'(m2 + m3);
        end
        m1 = n1; m2 = n2; m3 = n3; m4 = n4;
        e.val = n4; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: after each edge, compare both outputs with the oldest entry.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(dout, e.val, e.tag);
            check(scan_out, e.val, {e.tag, " R11 scan_out"});
        end
    end

    task automatic shift_word(input logic [W-1:0] w, input string tag);
        // Select parked on the din_b leg, loads low: the links must override.
        step(1'b1, w, 4'b0000, 1'b0, 16'hDEAD, 16'hBEEF, tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        #3;
        check(dout, '0, "R1 reset dout");
        check(scan_out, '0, "R1 reset scan_out");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 latency: a single word emerges after four edges, zeros before.
        shift_word(16'hA5A1, "R2 depth");
        shift_word(16'h0000, "R2 depth");
        shift_word(16'h0000, "R2 depth");
        shift_word(16'h0000, "R2 depth, word out at fourth edge");

        // R3 R4 R5: fill the chain with distinct words, ignoring sel_r2 and loads.
        shift_word(16'h1111, "R3 R4 R5 chain fill");
        shift_word(16'h2222, "R3 R4 R5 chain fill");
        shift_word(16'h3333, "R3 R4 R5 chain fill");
        shift_word(16'h4444, "R3 R4 R5 chain fill");
        step(1'b1, 16'h5555, 4'b1111, 1'b0, 16'h0F0F, 16'hF0F0, "R3 R4 R5 loads high in shift");

        // R6 R7: functional loads of the first two stages.
        step(1'b0, 16'h9999, 4'b0001, 1'b0, 16'h1234, 16'h0000, "R6 load din_a");
        step(1'b0, 16'h9999, 4'b0010, 1'b1, 16'h0000, 16'hCAFE, "R7 sel 1 takes first stage");
        step(1'b0, 16'h9999, 4'b0100, 1'b0, 16'h0000, 16'h0000, "R8 direct load");
        step(1'b0, 16'h9999, 4'b0010, 1'b0, 16'h7777, 16'hFFF0, "R7 sel 0 takes din_b");
        step(1'b0, 16'h9999, 4'b1000, 1'b0, 16'h0000, 16'h0000, "R9 sum load");

        // R10: loads low, inputs moving.
        step(1'b0, 16'hAAAA, 4'b0000, 1'b1, 16'hFFFF, 16'hFFFF, "R10 hold");
        step(1'b0, 16'h5555, 4'b0000, 1'b0, 16'h0001, 16'h8000, "R10 hold");

        // R9 wrap: stage3 = 0x1234, stage2 = 0xFFF0, sum wraps.
        step(1'b0, 16'h0000, 4'b1000, 1'b0, 16'h0000, 16'h0000, "R9 sum wraps");
        step(1'b0, 16'h0000, 4'b0100, 1'b0, 16'h0000, 16'h0000, "R8 direct load again");
        step(1'b0, 16'h0000, 4'b1000, 1'b0, 16'h0000, 16'h0000, "R9 sum of equal stages");

        // Scan out the inner stages to observe R6 R7 R8 results.
        shift_word(16'hC001, "R4 R6 R7 R8 unload");
        shift_word(16'hC002, "R3 R6 R7 unload");
        shift_word(16'hC003, "R5 R6 unload");
        shift_word(16'hC004, "R2 unload");
        shift_word(16'hC005, "R2 unload");

        // Mixed: functional cycle between shifts.
        step(1'b0, 16'h0000, 4'b0001, 1'b0, 16'h4321, 16'h0000, "R6 load between shifts");
        shift_word(16'h0000, "R3 shift after load");
        shift_word(16'h0000, "R4 shift after load");
        shift_word(16'h0000, "R5 shift after load");
        shift_word(16'h0000, "R2 loaded word out");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule